// File: doc/BRIEF.md
# Ternary CAM Lookup Engine

This block is a ternary content-addressable memory with `2**IDX_W` entries. Each entry stores a key, a per-bit don't-care pattern and a valid flag in flip-flops. The stored pattern for each entry is compared against an incoming lookup key in the same cycle. A separate simple dual-port word table holds one data word per entry. It is read at each matching index.

An update port writes or erases one entry per cycle. A lookup port with a valid/ready handshake accepts a key. It then returns one result per matching entry, in rising index order and on consecutive cycles. When nothing matches, it returns a single miss result. A hit result carries the entry index and its data word.

While a lookup with several hits is still being drained, the lookup port refuses new keys. A build-time switch turns the don't-care patterns off, so that matching becomes plain key equality.

Top module: `tcam_engine`

## Requirements
- R1: Entry i matches a lookup key when every key bit either equals the stored bit or has its stored don't-care bit at 1. In other words, `((stored_key ^ lookup_key) & ~stored_dc) == 0`.
- R2: With `EXACT_ONLY=1`, the stored don't-care bits have no effect, and an entry matches only when its key equals the lookup key exactly.
- R3: When `upd_en` is high and `upd_erase` is low at a clock edge, `upd_key`, `upd_dc` and `upd_word` are stored at entry `upd_idx` and the entry becomes valid. A lookup accepted at the next edge sees the new contents.
- R4: When `upd_en` and `upd_erase` are both high at a clock edge, entry `upd_idx` becomes invalid. An invalid entry never matches.
- R5: The first result of a lookup accepted at edge T (`lk_valid && lk_ready`) appears on the outputs right after edge T+3. A hit result carries `hit_idx` and the `hit_word` stored for that index.
- R6: When no valid entry matches, exactly one result is produced, with `hit_valid=1` and `hit_miss=1`. `hit_miss` is never high without `hit_valid`.
- R7: A lookup with k matches (k at least 1) produces k results with `hit_miss=0` on k consecutive cycles, in strictly ascending `hit_idx` order.
- R8: `lk_ready` is low from the cycle after accepting a lookup with two or more matches until the edge at which its last match leaves the encoder. For a lookup with fewer than two matches, `lk_ready` stays high.
- R9: A synchronous active-high `rst` invalidates all entries, clears pending work and holds `hit_valid` low. After reset, `lk_ready` is high and any lookup misses.
- R10: When an update and an accepted lookup share an edge, the compare uses the entry contents from before the update. The returned `hit_word` is read two edges later, so it is the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| upd_en | input | 1 | Perform an update this cycle |
| upd_erase | input | 1 | 1: invalidate entry, 0: write entry |
| upd_idx | input | IDX_W | Entry being updated |
| upd_key | input | KEY_W | Key to store |
| upd_dc | input | KEY_W | Don't-care bits to store (1 = ignore bit) |
| upd_word | input | WORD_W | Data word to store |
| lk_valid | input | 1 | Lookup key offered |
| lk_ready | output | 1 | Lookup port can accept a key |
| lk_key | input | KEY_W | Lookup key |
| hit_valid | output | 1 | A result is present |
| hit_miss | output | 1 | Result is "not found" |
| hit_idx | output | IDX_W | Matching entry index |
| hit_word | output | WORD_W | Data word of that entry |

## Verification
Lookups are made with keys that equal a stored key, with keys that differ only in don't-care positions, and with keys that differ in cared-for bits. These tell the masked compare apart from exact equality. An exact-only instance runs on the same stimulus, which shows that the switch removes the don't-care effect. Tables with no valid entry, a single hit, several hits and every entry hitting separate the miss path, the one-result path and the ordered drain with its ready stall. An update that lands in the same cycle as a lookup shows which contents the compare uses and which word is returned.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

  // Control flags that travel alongside an index through the lookup pipe.
  typedef struct packed {
    logic vld;
    logic miss;
  } res_tag_t;

  localparam int DEF_IDX_W  = 3;
  localparam int DEF_KEY_W  = 8;
  localparam int DEF_WORD_W = 8;

endpackage

// File: rtl/tcam_entry.sv
module tcam_entry #(
  parameter int KEY_W      = 8,
  parameter bit EXACT_ONLY = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             erase,
  input  logic [KEY_W-1:0] key_in,
  input  logic [KEY_W-1:0] dc_in,
  input  logic [KEY_W-1:0] probe,
  output logic             hit
);

  logic             vld_q;
  logic [KEY_W-1:0] key_q;
  logic [KEY_W-1:0] dc_q;
  logic [KEY_W-1:0] dc_eff;

  // Bits that disagree and are not marked don't-care.
  function automatic logic [KEY_W-1:0] cared_diff(input logic [KEY_W-1:0] a,
                                                  input logic [KEY_W-1:0] b,
                                                  input logic [KEY_W-1:0] dc);
    return (a ^ b) & ~dc;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
    end else if (wr) begin
      vld_q <= ~erase;
    end
  end

  always_ff @(posedge clk) begin
    if (wr && !erase) begin
      key_q <= key_in;
      dc_q  <= dc_in;
    end
  end

  generate
    if (EXACT_ONLY) begin : g_exact
      assign dc_eff = '0 & dc_q;
    end else begin : g_tern
      assign dc_eff = dc_q;
    end
  endgenerate

  assign hit = vld_q && (cared_diff(key_q, probe, dc_eff) == '0);

endmodule

// File: rtl/tcam_scan.sv
module tcam_scan #(
  parameter int IDX_W = 3,
  localparam int N    = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             m_vld,
  input  logic [N-1:0]     m_vec,
  output logic             busy,
  output tcam_pkg::res_tag_t sel_tag,
  output logic [IDX_W-1:0] sel_idx
);

  logic [N-1:0]     pend_q;
  logic [N-1:0]     src;
  logic             take;
  logic [IDX_W-1:0] lo;

  function automatic logic [IDX_W-1:0] lowest_idx(input logic [N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  function automatic logic more_than_one(input logic [N-1:0] v);
    return |(v & (v - N'(1)));
  endfunction

  assign src  = (pend_q != '0) ? pend_q : m_vec;
  assign take = (pend_q != '0) || m_vld;
  assign lo   = lowest_idx(src);
  assign busy = (pend_q != '0) || (m_vld && more_than_one(m_vec));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q       <= '0;
      sel_tag.vld  <= 1'b0;
      sel_tag.miss <= 1'b0;
      sel_idx      <= '0;
    end else begin
      sel_tag.vld  <= take;
      sel_tag.miss <= take && (src == '0);
      sel_idx      <= lo;
      if (take) pend_q <= src & ~(N'(1) << lo);
    end
  end

endmodule

// File: rtl/tcam_wordram.sv
module tcam_wordram #(
  parameter int ADDR_W = 3,
  parameter int WORD_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/tcam_engine.sv
module tcam_engine #(
  parameter int IDX_W      = tcam_pkg::DEF_IDX_W,
  parameter int KEY_W      = tcam_pkg::DEF_KEY_W,
  parameter int WORD_W     = tcam_pkg::DEF_WORD_W,
  parameter bit EXACT_ONLY = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_en,
  input  logic              upd_erase,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic [KEY_W-1:0]  upd_key,
  input  logic [KEY_W-1:0]  upd_dc,
  input  logic [WORD_W-1:0] upd_word,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [KEY_W-1:0]  lk_key,
  output logic              hit_valid,
  output logic              hit_miss,
  output logic [IDX_W-1:0]  hit_idx,
  output logic [WORD_W-1:0] hit_word
);

  localparam int N = 1 << IDX_W;

  logic [N-1:0]        hits;
  logic [N-1:0]        m_vec_q;
  logic                m_vld_q;
  logic                lk_fire;
  logic                scan_busy;
  tcam_pkg::res_tag_t  sel_tag;
  logic [IDX_W-1:0]    sel_idx;
  tcam_pkg::res_tag_t  p2_tag;
  logic [IDX_W-1:0]    p2_idx;
  logic [WORD_W-1:0]   rd_word;

  assign lk_ready = ~scan_busy;
  assign lk_fire  = lk_valid && lk_ready;

  // Entry array: every line compares against the lookup key in parallel.
  for (genvar i = 0; i < N; i++) begin : g_line
    tcam_entry #(.KEY_W(KEY_W), .EXACT_ONLY(EXACT_ONLY)) u_line (
      .clk    (clk),
      .rst    (rst),
      .wr     (upd_en && (upd_idx == IDX_W'(i))),
      .erase  (upd_erase),
      .key_in (upd_key),
      .dc_in  (upd_dc),
      .probe  (lk_key),
      .hit    (hits[i])
    );
  end

  // Stage 1: capture the match vector (pre-update contents).
  always_ff @(posedge clk) begin
    if (rst) begin
      m_vld_q <= 1'b0;
      m_vec_q <= '0;
    end else begin
      m_vld_q <= lk_fire;
      m_vec_q <= hits;
    end
  end

  // Stage 2: sequential encoder, one index per cycle.
  tcam_scan #(.IDX_W(IDX_W)) u_scan (
    .clk     (clk),
    .rst     (rst),
    .m_vld   (m_vld_q),
    .m_vec   (m_vec_q),
    .busy    (scan_busy),
    .sel_tag (sel_tag),
    .sel_idx (sel_idx)
  );

  // Stage 3: word table read.
  tcam_wordram #(.ADDR_W(IDX_W), .WORD_W(WORD_W)) u_ram (
    .clk   (clk),
    .we    (upd_en && !upd_erase),
    .waddr (upd_idx),
    .wdata (upd_word),
    .re    (sel_tag.vld),
    .raddr (sel_idx),
    .rdata (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      p2_tag    <= '0;
      p2_idx    <= '0;
      hit_valid <= 1'b0;
      hit_miss  <= 1'b0;
      hit_idx   <= '0;
      hit_word  <= '0;
    end else begin
      p2_tag    <= sel_tag;
      p2_idx    <= sel_idx;
      hit_valid <= p2_tag.vld;
      hit_miss  <= p2_tag.miss;
      hit_idx   <= p2_idx;
      hit_word  <= rd_word;
    end
  end

endmodule

// File: rtl/tcam_engine_checks.sv
module tcam_engine_checks #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_fire,
  input logic             lk_ready,
  input logic             hit_valid,
  input logic             hit_miss,
  input logic [IDX_W-1:0] hit_idx
);

  // R5: an accepted lookup always shows a result three edges later.
  p_latency_r5: assert property (@(posedge clk) disable iff (rst)
    lk_fire |-> ##4 hit_valid);

  // R6: a miss is always a valid result.
  p_miss_valid_r6: assert property (@(posedge clk) disable iff (rst)
    hit_miss |-> hit_valid);

  // R7: follow-on results continue an ascending run of hits.
  p_ascend_r7: assert property (@(posedge clk) disable iff (rst)
    (hit_valid && !$past(lk_fire, 4)) |->
      ($past(hit_valid) && !hit_miss && !$past(hit_miss) && (hit_idx > $past(hit_idx))));

  // R8: a follow-on hit implies the port was stalled while it waited.
  p_stall_r8: assert property (@(posedge clk) disable iff (rst)
    (hit_valid && !$past(lk_fire, 4)) |-> !$past(lk_ready, 3));

  // R9: reset leaves no result on the outputs.
  p_reset_quiet_r9: assert property (@(posedge clk)
    rst |=> !hit_valid);

endmodule

bind tcam_engine tcam_engine_checks #(.IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lk_fire   (lk_fire),
  .lk_ready  (lk_ready),
  .hit_valid (hit_valid),
  .hit_miss  (hit_miss),
  .hit_idx   (hit_idx)
);

// File: tb/tcam_engine_bench.sv
module tcam_engine_bench;

  localparam int CLK_PERIOD = 10;
  localparam int IDX_W  = 3;
  localparam int KEY_W  = 8;
  localparam int WORD_W = 8;
  localparam int N      = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic upd_en = 1'b0, upd_erase = 1'b0;
  logic [IDX_W-1:0]  upd_idx = '0;
  logic [KEY_W-1:0]  upd_key = '0, upd_dc = '0, lk_key = '0;
  logic [WORD_W-1:0] upd_word = '0;
  logic lk_valid = 1'b0;

  logic a_rdy, a_v, a_m, b_rdy, b_v, b_m;
  logic [IDX_W-1:0]  a_i, b_i;
  logic [WORD_W-1:0] a_w, b_w;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcam_engine #(.IDX_W(IDX_W), .KEY_W(KEY_W), .WORD_W(WORD_W), .EXACT_ONLY(1'b0)) u_tcam_engine (
    .clk(clk), .rst(rst), .upd_en(upd_en), .upd_erase(upd_erase), .upd_idx(upd_idx),
    .upd_key(upd_key), .upd_dc(upd_dc), .upd_word(upd_word), .lk_valid(lk_valid),
    .lk_ready(a_rdy), .lk_key(lk_key), .hit_valid(a_v), .hit_miss(a_m),
    .hit_idx(a_i), .hit_word(a_w));

  tcam_engine #(.IDX_W(IDX_W), .KEY_W(KEY_W), .WORD_W(WORD_W), .EXACT_ONLY(1'b1)) u_exact (
    .clk(clk), .rst(rst), .upd_en(upd_en), .upd_erase(upd_erase), .upd_idx(upd_idx),
    .upd_key(upd_key), .upd_dc(upd_dc), .upd_word(upd_word), .lk_valid(lk_valid),
    .lk_ready(b_rdy), .lk_key(lk_key), .hit_valid(b_v), .hit_miss(b_m),
    .hit_idx(b_i), .hit_word(b_w));

  // Bench model of the table.
  logic [KEY_W-1:0]  mk [N];
  logic [KEY_W-1:0]  md [N];
  logic [WORD_W-1:0] mw [N];
  logic              mv [N];

  function automatic logic [N-1:0] expect_hits(input logic [KEY_W-1:0] key, input bit exact);
    logic [N-1:0] r = '0;
    for (int e = 0; e < N; e++) begin
      bit ok = mv[e];
      for (int b = 0; b < KEY_W; b++)
        if (mk[e][b] != key[b] && (exact || !md[e][b])) ok = 0;
      r[e] = ok;
    end
    return r;
  endfunction

  function automatic int count_of(input logic [N-1:0] v);
    int c = 0;
    for (int e = 0; e < N; e++) c += int'(v[e]);
    return c;
  endfunction

  function automatic int nth_set(input logic [N-1:0] v, input int n);
    int c = 0;
    for (int e = 0; e < N; e++) begin
      if (v[e]) begin
        if (c == n) return e;
        c++;
      end
    end
    return 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic put(input int idx, input bit erase, input logic [KEY_W-1:0] k,
                     input logic [KEY_W-1:0] dc, input logic [WORD_W-1:0] w);
    @(negedge clk);
    upd_en = 1; upd_erase = erase; upd_idx = IDX_W'(idx);
    upd_key = k; upd_dc = dc; upd_word = w;
    @(posedge clk);
    if (erase) mv[idx] = 0;
    else begin mv[idx] = 1; mk[idx] = k; md[idx] = dc; mw[idx] = w; end
    @(negedge clk);
    upd_en = 0;
  endtask

  // Lookup with optional update in the same cycle (R10).
  task automatic look(input logic [KEY_W-1:0] key, input bit with_upd, input int uidx,
                      input logic [KEY_W-1:0] uk, input logic [WORD_W-1:0] uw,
                      input string tag);
    logic [N-1:0] ha, hb;
    int ka, kb, span;
    ha = expect_hits(key, 0);
    hb = expect_hits(key, 1);
    ka = count_of(ha); kb = count_of(hb);
    span = ((ka > kb) ? ka : kb);
    if (span < 1) span = 1;
    @(negedge clk);
    lk_valid = 1; lk_key = key;
    if (with_upd) begin
      upd_en = 1; upd_erase = 0; upd_idx = IDX_W'(uidx); upd_key = uk; upd_dc = '0; upd_word = uw;
    end
    @(posedge clk);
    if (with_upd) begin mv[uidx] = 1; mk[uidx] = uk; md[uidx] = '0; mw[uidx] = uw; end
    for (int j = 0; j < span + 4; j++) begin
      @(negedge clk);
      if (j == 0) begin lk_valid = 0; upd_en = 0; end
      // R8: stall while more than one hit remains to drain
      chk(a_rdy == !(ka >= 2 && j < ka), {tag, " R8 ready"}, a_rdy, !(ka >= 2 && j < ka));
      chk(b_rdy == !(kb >= 2 && j < kb), {tag, " R8 ready exact"}, b_rdy, !(kb >= 2 && j < kb));
      if (j >= 3) begin
        int n = j - 3;
        bit ev_a = (n < ka) || (ka == 0 && n == 0);
        bit ev_b = (n < kb) || (kb == 0 && n == 0);
        // R5 and R7: result timing and ascending order
        chk(a_v == ev_a, {tag, " R5 R7 valid"}, a_v, ev_a);
        chk(b_v == ev_b, {tag, " R2 valid exact"}, b_v, ev_b);
        if (ev_a) begin
          // R6: miss flag
          chk(a_m == (ka == 0), {tag, " R6 miss"}, a_m, ka == 0);
          if (ka != 0) begin
            chk(a_i == IDX_W'(nth_set(ha, n)), {tag, " R1 R7 idx"}, a_i, nth_set(ha, n));
            chk(a_w == mw[nth_set(ha, n)], {tag, " R5 R10 word"}, a_w, mw[nth_set(ha, n)]);
          end
        end
        if (ev_b) begin
          chk(b_m == (kb == 0), {tag, " R2 miss exact"}, b_m, kb == 0);
          if (kb != 0)
            chk(b_i == IDX_W'(nth_set(hb, n)), {tag, " R2 idx exact"}, b_i, nth_set(hb, n));
        end
      end
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int e = 0; e < N; e++) begin mv[e] = 0; mk[e] = '0; md[e] = '0; mw[e] = '0; end
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk(a_v == 0, "R9 no result in reset", a_v, 0);
    rst = 0;
    @(negedge clk);
    chk(a_rdy == 1, "R9 ready after reset", a_rdy, 1);
    chk(a_v == 0, "R9 quiet after reset", a_v, 0);
    look(8'h00, 0, 0, 0, 0, "R9 empty");

    // R3 / R1: single and masked hits
    put(2, 0, 8'hA5, 8'h00, 8'h11);
    look(8'hA5, 0, 0, 0, 0, "R3 single");
    put(5, 0, 8'hA0, 8'h0F, 8'h55);
    look(8'hA5, 0, 0, 0, 0, "R1 masked pair");
    look(8'hA9, 0, 0, 0, 0, "R1 dc only");
    look(8'hB5, 0, 0, 0, 0, "R1 cared bit");
    // R4: erase
    put(2, 1, 0, 0, 0);
    look(8'hA5, 0, 0, 0, 0, "R4 erased");
    put(5, 1, 0, 0, 0);
    look(8'hA5, 0, 0, 0, 0, "R6 none left");
    // R7 / R8: all entries hit
    for (int e = 0; e < N; e++) put(e, 0, 8'(e), 8'hFF, 8'(8'h30 + e));
    look(8'h3C, 0, 0, 0, 0, "R7 all hit");
    // R10: update lands with the lookup
    for (int e = 0; e < N; e++) put(e, 1, 0, 0, 0);
    put(4, 0, 8'h66, 8'h00, 8'h01);
    look(8'h66, 1, 4, 8'h77, 8'hEE, "R10 same cycle");
    look(8'h66, 0, 0, 0, 0, "R10 after");
    look(8'h77, 0, 0, 0, 0, "R3 new key");

    // Random mix
    for (int t = 0; t < 60; t++) begin
      int e = int'($urandom_range(N - 1));
      if ($urandom_range(3) == 0)
        put(e, $urandom_range(4) == 0, 8'($urandom), 8'($urandom & $urandom & $urandom), 8'($urandom));
      else begin
        logic [KEY_W-1:0] k = mk[int'($urandom_range(N - 1))];
        if ($urandom_range(2) == 0) k = k ^ (8'(1) << $urandom_range(KEY_W - 1));
        look(k, 0, 0, 0, 0, "R1 random");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule